// File: doc/BRIEF.md
# Last Exception Branch Recorder

This block follows the stream of retired taken branches and keeps the source and destination of the newest one in a private shadow pair. When an exception or interrupt is delivered, the shadow pair is frozen into a visible record pair. Software or a debug agent can read either address back through a single combinational read port.

The frozen record depends on the operating mode flags in the same cycle as the exception strobe. In legacy mode, with long mode off, only the low 32 bits of each address are kept. In compatibility submode the upper 32 bits are forced to zero. In 64-bit submode both full 64-bit addresses are stored. Branches keep overwriting the shadow pair, and the visible record changes only on the exception strobe. When a branch and an exception arrive in the same cycle, the exception freezes the branch that came before, and the new branch waits in the shadow pair for the next exception.

A small tracker state machine guards the shadow pair. It has two states. `TRK_EMPTY` is entered on reset and means that no branch has retired since then. `TRK_HELD` means that the shadow pair holds a real branch. The transition `EMPTY->HELD` is taken on the first branch strobe. `HELD->HELD` is taken on every later cycle. Reset is the only way back to `TRK_EMPTY`. An exception freezes the shadow pair only while the tracker is in `TRK_HELD`.

Top module: `ler_recorder`

## Requirements
- R1: After reset both records read back as zero.
- R2: Branch strobes without an exception strobe leave both records unchanged.
- R3: On an exception strobe, the records take the source and destination of the most recent taken branch before that cycle.
- R4: With `long_en`=0 (legacy mode), bits 63:32 of both records are zero and bits 31:0 hold the addresses, whatever `sub64` is.
- R5: With `long_en`=1 and `sub64`=0 (compatibility), bits 63:32 of both records are zero and bits 31:0 hold the addresses.
- R6: With `long_en`=1 and `sub64`=1 (64-bit), all 64 bits of both addresses are recorded.
- R7: When a branch strobe and an exception strobe share a cycle, the records take the branch before it, and the new branch is the one frozen by the next exception.
- R8: `rd_sel`=0 returns the source record and `rd_sel`=1 returns the destination record in the same cycle, with no clock edge in between.
- R9: The truncation uses the mode flags in the exception cycle, not the flags present when the branch retired.
- R10: An exception before any branch since reset leaves both records at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken-branch retire strobe |
| br_src | input | 64 | Source address of the retiring branch |
| br_dst | input | 64 | Destination address of the retiring branch |
| exc_valid | input | 1 | Exception/interrupt delivery strobe |
| long_en | input | 1 | Long mode enabled |
| sub64 | input | 1 | 64-bit submode (1) or compatibility submode (0); used only when long_en=1 |
| rd_sel | input | 1 | 0 selects the source record, 1 selects the destination record |
| rd_data | output | 64 | Selected record |

## Verification
The test addresses carry distinct nonzero upper and lower halves, so a record that wrongly truncates, or wrongly keeps, bits 63:32 shows up on its own. Each mode is exercised in turn: legacy mode with `sub64` both set and clear, compatibility and 64-bit. This tells apart a decoder that checks only `sub64` from one that checks `long_en` first. Several patterns are tried:
- Branches with no exception show that the record holds still.
- An exception before any branch shows that the record stays at zero.
- A branch and an exception in the same cycle, followed by a lone exception, show the ordering between the shadow pair and the record.
- A branch retired under compatibility flags and frozen under 64-bit flags shows which cycle's mode is used.

// File: rtl/ler_pkg.sv
package ler_pkg;
    localparam int unsigned ADDR_W = 64;
    localparam int unsigned LOW_W  = 32;
    localparam int unsigned HIGH_W = ADDR_W - LOW_W;
    localparam int unsigned NUM_ADDR = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t src;
        addr_t dst;
    } pair_t;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_COMPAT = 2'd1,
        MODE_FULL   = 2'd2
    } mode_e;

    typedef enum logic {
        TRK_EMPTY = 1'b0,
        TRK_HELD  = 1'b1
    } trk_e;

    function automatic mode_e decode_mode(input logic long_en, input logic sub64);
        if (!long_en)  return MODE_LEGACY;
        else if (sub64) return MODE_FULL;
        else           return MODE_COMPAT;
    endfunction
endpackage

// File: rtl/ler_addr_mask.sv
module ler_addr_mask
    import ler_pkg::*;
(
    input  mode_e mode,
    input  pair_t raw,
    output pair_t masked
);
    addr_t raw_arr [NUM_ADDR];
    addr_t out_arr [NUM_ADDR];
    logic  keep_high;

    always_comb begin
        unique case (mode)
            MODE_FULL:   keep_high = 1'b1;
            MODE_COMPAT: keep_high = 1'b0;
            MODE_LEGACY: keep_high = 1'b0;
            default:     keep_high = 1'b0;
        endcase
    end

    assign raw_arr[0] = raw.src;
    assign raw_arr[1] = raw.dst;

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_lane
        assign out_arr[i] = {raw_arr[i][ADDR_W-1:LOW_W] & {HIGH_W{keep_high}},
                             raw_arr[i][LOW_W-1:0]};
    end

    assign masked.src = out_arr[0];
    assign masked.dst = out_arr[1];
endmodule

// File: rtl/ler_shadow.sv
module ler_shadow
    import ler_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  br_valid,
    input  pair_t br_pair,
    output pair_t shadow,
    output trk_e  state
);
    trk_e  state_q, state_d;
    pair_t shadow_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_EMPTY: if (br_valid) state_d = TRK_HELD;
            TRK_HELD:  state_d = TRK_HELD;
            default:   state_d = TRK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        shadow_q <= '0;
        else if (br_valid) shadow_q <= br_pair;
    end

    assign shadow = shadow_q;
    assign state  = state_q;

    // R3: a branch always lands in the shadow pair on the next edge
    assert_shadow_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (shadow_q == $past(br_pair)));

    // R3: the tracker never returns to EMPTY once a branch is held
    assert_tracker_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_HELD) |=> (state_q == TRK_HELD));
endmodule

// File: rtl/ler_record.sv
module ler_record
    import ler_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  pair_t din,
    output pair_t rec
);
    pair_t rec_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    rec_q <= '0;
        else if (load) rec_q <= din;
    end

    assign rec = rec_q;

    // R2: without a freeze the visible record holds still
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rec_q));

    // R1: leaving reset, the record is zero
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rec_q == '0));
endmodule

// File: rtl/ler_recorder.sv
module ler_recorder
    import ler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_src,
    input  logic [ADDR_W-1:0] br_dst,
    input  logic              exc_valid,
    input  logic              long_en,
    input  logic              sub64,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rd_data
);
    pair_t br_pair, shadow, masked, rec;
    trk_e  trk_state;
    mode_e mode;
    logic  freeze;

    assign br_pair.src = br_src;
    assign br_pair.dst = br_dst;
    assign mode        = decode_mode(long_en, sub64);

    ler_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .br_pair  (br_pair),
        .shadow   (shadow),
        .state    (trk_state)
    );

    ler_addr_mask u_mask (
        .mode   (mode),
        .raw    (shadow),
        .masked (masked)
    );

    assign freeze = exc_valid && (trk_state == TRK_HELD);

    ler_record u_record (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (freeze),
        .din   (masked),
        .rec   (rec)
    );

    always_comb begin
        unique case (rd_sel)
            1'b0:    rd_data = rec.src;
            1'b1:    rd_data = rec.dst;
            default: rd_data = rec.src;
        endcase
    end

    // R4, R5: outside 64-bit submode the upper half of a fresh record is zero
    assert_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !(long_en && sub64)) |=>
            (rec.src[ADDR_W-1:LOW_W] == '0) && (rec.dst[ADDR_W-1:LOW_W] == '0));

    // R7: a same-cycle branch does not reach the record
    assert_prior_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> (rec.src[LOW_W-1:0] == $past(shadow.src[LOW_W-1:0])));

    // R6: in 64-bit submode the full shadow source is frozen
    assert_full_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && long_en && sub64) |=> (rec.src == $past(shadow.src)));

    // R10: no freeze happens before any branch was seen
    assert_empty_no_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && trk_state == TRK_EMPTY) |=> $stable(rec));
endmodule

// File: tb/ler_recorder_test.sv
module ler_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        br_valid, exc_valid, long_en, sub64, rd_sel;
    logic [63:0] br_src, br_dst, rd_data;

    int errors = 0;
    int checks = 0;

    string       q_tag [$];
    logic [63:0] q_src [$];
    logic [63:0] q_dst [$];

    logic [63:0] m_sf = '0, m_st = '0, m_rf = '0, m_rt = '0;
    logic        m_held = 1'b0;

    always #10 clk = ~clk;

    ler_recorder uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
        .br_dst(br_dst), .exc_valid(exc_valid), .long_en(long_en),
        .sub64(sub64), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [63:0] trunc(input logic [63:0] a, input logic le, input logic s64);
        return (le && s64) ? a : {32'h0, a[31:0]};
    endfunction

    task automatic push_expect(input string tag);
        q_tag.push_back(tag);
        q_src.push_back(m_rf);
        q_dst.push_back(m_rt);
        wait (q_tag.size() == 0);
    endtask

    task automatic step(input logic b, input logic [63:0] s, input logic [63:0] d,
                        input logic e, input logic le, input logic s64);
        @(negedge clk);
        br_valid = b; br_src = s; br_dst = d;
        exc_valid = e; long_en = le; sub64 = s64;
        if (e && m_held) begin
            m_rf = trunc(m_sf, le, s64);
            m_rt = trunc(m_st, le, s64);
        end
        if (b) begin
            m_sf = s; m_st = d; m_held = 1'b1;
        end
        @(negedge clk);
        br_valid = 1'b0; exc_valid = 1'b0;
    endtask

    // monitor: pop expected pair, read both records through the read port (R8)
    initial begin
        forever begin
            wait (q_tag.size() > 0);
            #2 rd_sel = 1'b0;
            #2 checks++;
            if (rd_data !== q_src[0]) begin
                errors++;
                $display("FAIL %s R8 src: actual=%h expected=%h", q_tag[0], rd_data, q_src[0]);
            end
            rd_sel = 1'b1;
            #2 checks++;
            if (rd_data !== q_dst[0]) begin
                errors++;
                $display("FAIL %s R8 dst: actual=%h expected=%h", q_tag[0], rd_data, q_dst[0]);
            end
            void'(q_tag.pop_front());
            void'(q_src.pop_front());
            void'(q_dst.pop_front());
        end
    end

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; br_valid = 0; exc_valid = 0; long_en = 0; sub64 = 0; rd_sel = 0;
        br_src = '0; br_dst = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_expect("R1 reset");
        step(0, '0, '0, 1, 1, 1);
        push_expect("R10 exc before branch");
        step(1, 64'hA1A1_0000_1111_2222, 64'hA2A2_0000_3333_4444, 0, 1, 1);
        step(1, 64'hB1B1_0000_5555_6666, 64'hB2B2_0000_7777_8888, 0, 1, 1);
        push_expect("R2 branches only");
        step(0, '0, '0, 1, 1, 1);
        push_expect("R3 R6 full mode");
        step(0, '0, '0, 1, 0, 1);
        push_expect("R4 legacy sub64=1");
        step(0, '0, '0, 1, 1, 1);
        step(0, '0, '0, 1, 0, 0);
        push_expect("R4 legacy sub64=0");
        step(1, 64'hC1C1_C1C1_9999_AAAA, 64'hC2C2_C2C2_BBBB_CCCC, 0, 0, 0);
        step(0, '0, '0, 1, 1, 0);
        push_expect("R5 compat");
        step(1, 64'hD1D1_D1D1_0101_0202, 64'hD2D2_D2D2_0303_0404, 1, 1, 1);
        push_expect("R7 same cycle prior");
        step(0, '0, '0, 1, 1, 1);
        push_expect("R7 next exception");
        step(1, 64'hE1E1_E1E1_0505_0606, 64'hE2E2_E2E2_0707_0808, 0, 1, 0);
        step(0, '0, '0, 1, 1, 1);
        push_expect("R9 mode at exception");
        rst_n = 1'b0;
        m_sf = '0; m_st = '0; m_rf = '0; m_rt = '0; m_held = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        push_expect("R1 second reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule